// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a small register-driven SPI master that runs one half-duplex serial flash command at a time. Software loads a command word (opcode and 24-bit address), an optional 32-bit data word holding up to four write bytes, and then a control word. The control word gives the number of bytes to send, the number of bytes to receive, and a start bit. The engine then owns chip select, the serial clock and the output data line until the command is complete. Serial mode 0 is used: the clock idles low, and data is sampled on rising edges.

The outgoing byte stream is read from the two packed registers. Bytes received afterwards are written back into the data register, the first byte into the lowest byte lane, so software reads the reply as one little-endian word. A busy flag covers the whole transaction.

Nothing flows through a valid/ready stream here. The register port is a plain single-cycle write strobe that is always accepted, so there is no back-pressure. While the engine is busy, writes to the command and data registers are dropped, and so is any start.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, busy is 0 and data_rd is 0.
- R2: wr_sel 0 writes the command register (opcode in bits 7:0, address in bits 31:8). wr_sel 1 writes the data register, which data_rd always shows. wr_sel 2 is the control word: send count in bits 3:0, receive count in bits 6:4, start in bit 8.
- R3: A control write with bit 8 set while idle raises busy and drops cs_n on the next clock edge. A start written while busy is ignored.
- R4: Byte k of the outgoing stream is, in order: the opcode, address bits 23:16, address bits 15:8, address bits 7:0, then data bytes 7:0, 15:8, 23:16 and 31:24. Only the first send-count bytes go out, each MSB first.
- R5: Each SCLK half-period lasts half_div+1 clocks. The first rising edge comes one half-period after cs_n falls. mosi changes only while sclk is low, and miso is sampled on the rising edge.
- R6: The receive bytes follow the send bytes with no overlap, and mosi is held 0 during them. Each byte is taken MSB first, and received byte i lands in data bits 8i+7:8i. Byte lanes that are not received keep their value.
- R7: cs_n rises, and busy falls, at the end of the low half-period that follows the last bit. A transaction of N bits is busy for (2N+1)(half_div+1) clocks. A receive count of 0 ends the transaction right after the send phase.
- R8: A send count above 8 is treated as 8, and a receive count above 4 is treated as 4.
- R9: Writes to the command or data register while busy are ignored.
- R10: With both counts 0, cs_n pulses low for one half-period and sclk never toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 command, 1 data, 2 control) |
| wr_data | input | 32 | Register write value |
| half_div | input | DIV_W | SCLK half-period minus one, in clocks; hold stable while busy |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction in progress |
| data_rd | output | 32 | Data register contents |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |

## Verification
A behavioural model in the bench predicts cs_n, sclk, mosi and busy for every clock of each transaction, and the model is compared against the design on every clock. The bench targets these corner cases:
- Divider values of 0, 1, 2 and 3. A counter off by one would stretch or shrink every half-period.
- Receive counts that leave upper byte lanes untouched. A design that cleared or shifted the whole word would corrupt those lanes.
- Over-range counts. Without the clamp, the engine would clock out extra bits.
- Zero-length transactions. A design that mishandled them would emit a stray clock edge.

A start, a command write and a data write are all injected mid-transaction. A design that accepted any of them would restart the bit stream, or would send and return altered bytes.

// File: rtl/spi_fce_pkg.sv
package spi_fce_pkg;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = 2;
  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd2;

  localparam int TXC_W     = 4;
  localparam int RXC_W     = 3;
  localparam int TXC_LSB   = 0;
  localparam int RXC_LSB   = 4;
  localparam int START_BIT = 8;
  localparam int MAX_TX    = 8;
  localparam int MAX_RX    = 4;
  localparam int LANES     = DATA_W / 8;

  // bit counter must hold 8*(MAX_TX+MAX_RX); half counter one more bit
  localparam int BITS_W    = $clog2(8 * (MAX_TX + MAX_RX) + 1);
  localparam int HALF_W    = BITS_W + 1;

  typedef struct packed {
    logic [TXC_W-1:0] tx;
    logic [RXC_W-1:0] rx;
  } cnt_t;

  // outgoing byte k: opcode, address high..low, then data little-endian
  function automatic logic [7:0] tx_byte(input logic [DATA_W-1:0] cmd,
                                         input logic [DATA_W-1:0] dat,
                                         input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = cmd[7:0];
      3'd1:    b = cmd[31:24];
      3'd2:    b = cmd[23:16];
      3'd3:    b = cmd[15:8];
      3'd4:    b = dat[7:0];
      3'd5:    b = dat[15:8];
      3'd6:    b = dat[23:16];
      default: b = dat[31:24];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/spi_fce_regs.sv
module spi_fce_regs
  import spi_fce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              rx_we,
  input  logic [1:0]        rx_lane,
  input  logic [7:0]        rx_byte,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              launch,
  output cnt_t              cnt_o
);
  logic [TXC_W-1:0] tx_raw;
  logic [RXC_W-1:0] rx_raw;
  logic             cmd_we, data_we;

  assign tx_raw  = wr_data[TXC_LSB +: TXC_W];
  assign rx_raw  = wr_data[RXC_LSB +: RXC_W];
  assign cmd_we  = wr_en && (wr_sel == SEL_CMD)  && !busy;
  assign data_we = wr_en && (wr_sel == SEL_DATA) && !busy;
  assign launch  = wr_en && (wr_sel == SEL_CTRL) && wr_data[START_BIT] && !busy;

  always_comb begin
    cnt_o.tx = (tx_raw > TXC_W'(MAX_TX)) ? TXC_W'(MAX_TX) : tx_raw;
    cnt_o.rx = (rx_raw > RXC_W'(MAX_RX)) ? RXC_W'(MAX_RX) : rx_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= wr_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_q[8*g +: 8] <= '0;
      else if (data_we)
        data_q[8*g +: 8] <= wr_data[8*g +: 8];
      else if (rx_we && (rx_lane == 2'(g)))
        data_q[8*g +: 8] <= rx_byte;
    end
  end

  a_r9_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  a_r6_rx_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> busy);
endmodule

// File: rtl/spi_fce_clkdiv.sv
module spi_fce_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!run || cnt_q == '0)   cnt_q <= half_div;
    else                            cnt_q <= cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);

  a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half_div != '0) |=> !tick);
endmodule

// File: rtl/spi_fce_seq.sv
module spi_fce_seq
  import spi_fce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  cnt_t              cnt_i,
  input  logic [DATA_W-1:0] cmd_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_we,
  output logic [1:0]        rx_lane,
  output logic [7:0]        rx_byte
);
  localparam int CW = BITS_W - 3;

  logic              busy_q;
  logic [HALF_W-1:0] h_q;
  logic [BITS_W-1:0] nbits_q, txbits_q;
  logic [6:0]        sh_q;

  logic [BITS_W-1:0] bit_idx;
  logic [4:0]        rx_pos;
  logic              in_tx, last_half, rise, sample;
  logic [7:0]        cur_byte;

  assign bit_idx   = h_q[HALF_W-1:1];
  assign in_tx     = bit_idx < txbits_q;
  assign rx_pos    = 5'(bit_idx - txbits_q);
  assign last_half = (h_q == {nbits_q, 1'b0});
  assign rise      = busy_q && tick && !h_q[0] && !last_half;
  assign sample    = rise && !in_tx;
  assign cur_byte  = tx_byte(cmd_q, data_q, bit_idx[5:3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      h_q      <= '0;
      nbits_q  <= '0;
      txbits_q <= '0;
      sh_q     <= '0;
    end else begin
      if (launch) begin
        busy_q   <= 1'b1;
        h_q      <= '0;
        nbits_q  <= {CW'(cnt_i.tx) + CW'(cnt_i.rx), 3'b000};
        txbits_q <= {CW'(cnt_i.tx), 3'b000};
      end else if (busy_q && tick) begin
        if (last_half) busy_q <= 1'b0;
        else           h_q    <= h_q + 1'b1;
      end
      if (sample) sh_q <= {sh_q[5:0], miso};
    end
  end

  assign busy    = busy_q;
  assign cs_n    = !busy_q;
  assign sclk    = busy_q && h_q[0];
  assign mosi    = busy_q && in_tx && cur_byte[~bit_idx[2:0]];
  assign rx_we   = sample && (rx_pos[2:0] == 3'd7);
  assign rx_lane = rx_pos[4:3];
  assign rx_byte = {sh_q, miso};

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> ($stable(sclk) && $stable(mosi) && $stable(cs_n)));
  a_r5_mosi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mosi)) |-> !sclk);
  a_r6_rx_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> !mosi);
  a_r7_release_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(!sclk));
endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
  import spi_fce_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              miso,
  output logic              busy,
  output logic [DATA_W-1:0] data_rd,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi
);
  logic [DATA_W-1:0] cmd_q, data_q;
  logic              launch, tick, rx_we;
  logic [1:0]        rx_lane;
  logic [7:0]        rx_byte;
  cnt_t              cnt;

  spi_fce_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte),
    .cmd_q(cmd_q), .data_q(data_q), .launch(launch), .cnt_o(cnt)
  );

  spi_fce_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_div), .tick(tick)
  );

  spi_fce_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cnt_i(cnt),
    .cmd_q(cmd_q), .data_q(data_q), .tick(tick), .miso(miso),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
  );

  assign data_rd = data_q;
endmodule

// File: tb/spi_flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_flash_cmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [7:0]  half_div = 8'd0;
  logic        miso = 1'b0;
  logic        busy, cs_n, sclk, mosi;
  logic [31:0] data_rd;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  bit pat [0:127];
  int redge = 0;

  always #2.5 clk = ~clk;

  spi_flash_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .half_div(half_div), .miso(miso), .busy(busy), .data_rd(data_rd),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
  );

  // flash model: presents bit r before rising edge r, shifts on falling edges
  always @(negedge cs_n) begin redge = 0; miso = pat[0]; end
  always @(posedge sclk) redge = redge + 1;
  always @(negedge sclk) if (!cs_n) miso = pat[redge];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] c, input logic [31:0] d,
                                          input int k);
    case (k)
      0: return c[7:0];
      1: return c[31:24];
      2: return c[23:16];
      3: return c[15:8];
      default: return d[8*(k-4) +: 8];
    endcase
  endfunction

  task automatic run_xact(input string tag, input logic [31:0] cmd, input logic [31:0] dat,
                          input int tx, input int rx, input int div,
                          input logic [31:0] sbytes, input bit inject);
    int txe, rxe, nb, d;
    int q[$];
    logic [31:0] expd;
    txe = (tx > 8) ? 8 : tx;
    rxe = (rx > 4) ? 4 : rx;
    nb  = 8 * (txe + rxe);
    d   = div + 1;
    half_div = 8'(div);
    wr(2'd0, cmd);
    wr(2'd1, dat);
    chk(data_rd == dat, "R2", {tag, " data register readback"}, data_rd, dat);
    // flash reply pattern indexed by rising edge
    for (int i = 0; i < 128; i++) begin
      if (i < 8*txe)                pat[i] = (i % 3 == 0);
      else if (i < nb)              pat[i] = sbytes[8*((i-8*txe)/8) + 7 - ((i-8*txe)%8)];
      else                          pat[i] = 1'b0;
    end
    // expected (cs_n, sclk, mosi) per clock
    for (int h = 0; h <= 2*nb; h++) begin
      int b, m;
      b = h / 2;
      m = (b < 8*txe) ? int'(exp_byte(cmd, dat, b/8) >> (7 - b%8)) & 1 : 0;
      for (int c = 0; c < d; c++) q.push_back(((h % 2) << 1) | m);
    end
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2;
    wr_data = (32'd1 << 8) | 32'(rx << 4) | 32'(tx);
    @(negedge clk);
    wr_en = 1'b0;
    foreach (q[i]) begin
      logic [2:0] a, e;
      a = {cs_n, sclk, mosi};
      e = 3'(q[i]);
      tests++;
      if (a !== e || busy !== 1'b1) begin
        fails++;
        $display("FAIL R3/R4/R5/R6 %s cycle %0d: actual cs/sclk/mosi/busy %b%b expected %b1",
                 tag, i, a, busy, e);
      end
      wr_en = 1'b0;
      if (inject && i == 3) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h0000_0101; end
      if (inject && i == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h0; end
      if (inject && i == 7) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hFFFF_FFFF; end
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(cs_n === 1'b1 && busy === 1'b0 && sclk === 1'b0, "R7", {tag, " released on time"},
        {29'd0, cs_n, busy, sclk}, 32'h4);
    expd = dat;
    for (int j = 0; j < rxe; j++) expd[8*j +: 8] = sbytes[8*j +: 8];
    chk(data_rd === expd, "R6", {tag, " data after transaction"}, data_rd, expd);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0 && busy === 1'b0, "R1",
        "idle lines in reset", {28'd0, cs_n, sclk, mosi, busy}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(data_rd === 32'h0, "R1", "data after reset", data_rd, 32'h0);
    // R4 R6: one-byte command, three reply bytes, divider 1
    run_xact("R4_id", 32'h0000_009F, 32'h0, 1, 3, 1, 32'h0017_20C2, 1'b0);
    // R9 R3 R7: full send, no receive, mid-run writes ignored
    run_xact("R9_prog", 32'h1234_5602, 32'hA1B2_C3D4, 8, 0, 0, 32'h0, 1'b1);
    // R4 R5 R6: opcode plus address then four reply bytes, divider 2
    run_xact("R5_read", 32'hABCD_EF03, 32'h0, 4, 4, 2, 32'h0199_3C5A, 1'b0);
    // R6: partial receive keeps upper lanes
    run_xact("R6_lanes", 32'h0000_0005, 32'hDEAD_BEEF, 1, 2, 0, 32'h0000_2211, 1'b0);
    // R8: over-range counts clamp to 8 and 4
    run_xact("R8_clamp", 32'h7766_5544, 32'h55AA_33CC, 15, 7, 0, 32'h8899_AABB, 1'b0);
    // R10: empty transaction
    run_xact("R10_empty", 32'h0, 32'h1357_9BDF, 0, 0, 3, 32'h0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule